// File: doc/BRIEF.md
# Eight-Channel Volume and Mute Controller

This block keeps the applied attenuation code for eight audio channels. Each channel has an 8-bit volume code in half-dB steps. Code 0 is +24 dB, code 48 (30h) is 0 dB, and each increment lowers the gain by 0.5 dB. A shared 8-bit master code adds further attenuation: master code 0 adds none, and each increment adds 0.5 dB. The block adds the two codes to form the channel's goal code. The applied code for a channel changes only when a sample for that channel is presented on the sample strobe. All decisions are made per sample.

A goal update can be made to wait for a zero crossing of the channel's own signal, which avoids audible zipper noise. There are two mute paths, and they behave differently. Mute requests ramp the applied code one step at a time. Hard conditions force silence at once: an all-ones code, a total attenuation beyond the -103 dB floor, or a long run of zero samples. The applied code 255 means silent. The gain multiplier that follows the block uses the applied codes.

Top module: `vol_mute_ctrl`

## Requirements
- R1: After reset every channel's applied code is 255 and every muted flag is high.
- R2: The goal code is channel code plus master code. The applied code changes only on a sample strobe for that channel. With zero-crossing gating off, the goal is taken on the channel's next sample.
- R3: A channel code of FFh, or a master code of FFh, sets the applied code to 255 on that channel's next sample. This holds whatever the gating setting and whatever the sample value.
- R4: A sum of channel code and master code above 254 (below -103 dB) gives applied code 255. A sum of exactly 254 is applied as 254.
- R5: A channel's muted flag is high exactly when its applied code is 255.
- R6: A mute request ramps the applied code up by one every 32 samples of that channel, until it reaches 255. The master mute acts on all channels. A channel mute acts on its own channel only.
- R7: When the mute request is withdrawn, the applied code ramps back toward the goal at the same rate of one step per 32 samples. Zero-crossing gating does not apply during this ramp.
- R8: With gating on, a new goal is taken only on a sample that is a crossing. A crossing is a sample that is zero, a sample whose previous sample was zero, or a sample whose sign bit (bit 23) differs from that of the previous sample. The first sample after reset counts as a crossing.
- R9: With zero-detect enabled, the 2048th consecutive zero sample on a channel sets that channel to 255. Other channels are not affected. With zero-detect disabled, a run of zeros has no effect.
- R10: The first non-zero sample releases a zero-detect mute, and the goal is applied on that sample. The zero run then starts again from zero, so a later 2047 zeros do not mute the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_chan_i | input | 3 | Channel index of the strobed sample |
| smp_data_i | input | 24 | Signed sample |
| ch_vol_i | input | 64 | Channel volume codes, channel c in bits 8c+7..8c |
| mstr_vol_i | input | 8 | Master attenuation code |
| mstr_mute_i | input | 1 | Soft mute for all channels |
| ch_mute_i | input | 8 | Soft mute per channel |
| zc_en_i | input | 1 | Zero-crossing gating of goal updates |
| zd_en_i | input | 1 | Zero-run automatic mute enable |
| atten_o | output | 64 | Applied codes, channel c in bits 8c+7..8c |
| muted_o | output | 8 | Per-channel muted flag |

## Verification
Random pairs of channel and master codes, with gating off, test the sum path against the two hard-mute paths. The pairs are biased toward FFh and toward sums around the 254 floor. Directed sequences of same-sign, opposite-sign and zero samples show whether an update waits for a crossing. They also show that a hard mute bypasses that wait. Mute ramps are sampled one sample before and one sample after each 32-sample step. This pins the ramp rate and shows that only the addressed channels move. Zero runs of 2047 and 2048 samples, both before and after a release, separate the exact threshold from a counter that is not cleared.

// File: rtl/volc_pkg.sv
package volc_pkg;
  localparam int unsigned CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_SILENT = '1;
  localparam logic [CODE_W:0] CODE_FLOOR = 9'd254;
endpackage

// File: rtl/volc_zero_watch.sv
module volc_zero_watch #(
  parameter int unsigned SMP_W    = 24,
  parameter int unsigned ZRUN_LEN = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             zd_en_i,
  output logic             zc_o,
  output logic             zd_o
);
  localparam int unsigned RUN_W = $clog2(ZRUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(ZRUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(ZRUN_LEN - 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             sign_q, sign_d;
  logic             zero_q, zero_d;
  logic             is_zero;

  always_comb begin
    is_zero = (smp_i == '0);
    zc_o    = is_zero | zero_q | (smp_i[SMP_W-1] != sign_q);
    zd_o    = zd_en_i & is_zero & (run_q >= RUN_LAST);
  end

  always_comb begin
    run_d  = run_q;
    sign_d = sign_q;
    zero_d = zero_q;
    if (hit_i) begin
      sign_d = smp_i[SMP_W-1];
      zero_d = is_zero;
      if (!is_zero)            run_d = '0;
      else if (run_q != RUN_MAX) run_d = run_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      sign_q <= 1'b0;
      zero_q <= 1'b1;
    end else if (hit_i) begin
      run_q  <= run_d;
      sign_q <= sign_d;
      zero_q <= zero_d;
    end
  end

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX); // R9
endmodule

// File: rtl/volc_gain_lane.sv
module volc_gain_lane
  import volc_pkg::*;
#(
  parameter int unsigned RAMP_DIV = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hit_i,
  input  code_t ch_code_i,
  input  code_t mv_code_i,
  input  logic  soft_i,
  input  logic  zc_i,
  input  logic  zd_i,
  input  logic  zc_en_i,
  output code_t code_o
);
  localparam int unsigned CNT_W = (RAMP_DIV > 2) ? $clog2(RAMP_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RAMP_DIV - 1);

  code_t            code_q, code_d, goal;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ramp_q, ramp_d;
  logic [CODE_W:0]  sum;
  logic             hard, tick;

  always_comb begin
    sum  = {1'b0, ch_code_i} + {1'b0, mv_code_i};
    goal = sum[CODE_W-1:0];
    hard = (ch_code_i == CODE_SILENT) | (mv_code_i == CODE_SILENT) |
           (sum > CODE_FLOOR) | zd_i;
    tick = (cnt_q == CNT_LAST);
  end

  always_comb begin
    code_d = code_q;
    cnt_d  = cnt_q;
    ramp_d = ramp_q;
    if (hit_i) begin
      if (hard) begin
        code_d = CODE_SILENT;
        cnt_d  = '0;
        ramp_d = 1'b0;
      end else if (soft_i) begin
        ramp_d = 1'b1;
        cnt_d  = tick ? '0 : cnt_q + CNT_W'(1);
        if (tick && code_q != CODE_SILENT) code_d = code_q + 8'd1;
      end else if (ramp_q) begin
        if (code_q == goal) begin
          ramp_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = tick ? '0 : cnt_q + CNT_W'(1);
          if (tick) code_d = (code_q > goal) ? code_q - 8'd1 : code_q + 8'd1;
        end
      end else begin
        cnt_d = '0;
        if (code_q != goal && (zc_i || !zc_en_i)) code_d = goal;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_SILENT;
      cnt_q  <= '0;
      ramp_q <= 1'b0;
    end else if (hit_i) begin
      code_q <= code_d;
      cnt_q  <= cnt_d;
      ramp_q <= ramp_d;
    end
  end

  assign code_o = code_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |=> $stable(code_q)); // R2
  AST_HARD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && (ch_code_i == CODE_SILENT || mv_code_i == CODE_SILENT) |=> code_q == CODE_SILENT); // R3
  AST_BELOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && (sum > CODE_FLOOR) |=> code_q == CODE_SILENT); // R4
  AST_SOFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && soft_i && !hard |=> (code_q == $past(code_q)) || (code_q == $past(code_q) + 8'd1)); // R6
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && zc_en_i && !zc_i && !soft_i && !hard && !ramp_q |=> $stable(code_q)); // R8
  AST_ZERO_RUN_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && zd_i |=> code_q == CODE_SILENT); // R9
endmodule

// File: rtl/vol_mute_ctrl.sv
module vol_mute_ctrl
  import volc_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned SMP_W    = 24,
  parameter int unsigned ZRUN_LEN = 2048,
  parameter int unsigned RAMP_DIV = 32,
  localparam int unsigned CH_W    = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid_i,
  input  logic [CH_W-1:0]          smp_chan_i,
  input  logic [SMP_W-1:0]         smp_data_i,
  input  logic [NUM_CH*CODE_W-1:0] ch_vol_i,
  input  logic [CODE_W-1:0]        mstr_vol_i,
  input  logic                     mstr_mute_i,
  input  logic [NUM_CH-1:0]        ch_mute_i,
  input  logic                     zc_en_i,
  input  logic                     zd_en_i,
  output logic [NUM_CH*CODE_W-1:0] atten_o,
  output logic [NUM_CH-1:0]        muted_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic  hit, zc, zd;
    code_t code;

    assign hit = smp_valid_i && (smp_chan_i == CH_W'(c));

    volc_zero_watch #(.SMP_W(SMP_W), .ZRUN_LEN(ZRUN_LEN)) zw_i (
      .clk(clk), .rst_n(rst_n), .hit_i(hit), .smp_i(smp_data_i),
      .zd_en_i(zd_en_i), .zc_o(zc), .zd_o(zd)
    );

    volc_gain_lane #(.RAMP_DIV(RAMP_DIV)) lane_i (
      .clk(clk), .rst_n(rst_n), .hit_i(hit),
      .ch_code_i(ch_vol_i[c*CODE_W +: CODE_W]), .mv_code_i(mstr_vol_i),
      .soft_i(mstr_mute_i | ch_mute_i[c]), .zc_i(zc), .zd_i(zd),
      .zc_en_i(zc_en_i), .code_o(code)
    );

    assign atten_o[c*CODE_W +: CODE_W] = code;
    assign muted_o[c] = (code == CODE_SILENT);
  end
endmodule

// File: tb/vol_mute_ctrl_tb_top.sv
module vol_mute_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [2:0]  smp_chan;
  logic [23:0] smp_data;
  logic [63:0] ch_vol;
  logic [7:0]  mstr_vol;
  logic        mstr_mute;
  logic [7:0]  ch_mute;
  logic        zc_en, zd_en;
  logic [63:0] atten;
  logic [7:0]  muted;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vol_mute_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid), .smp_chan_i(smp_chan),
    .smp_data_i(smp_data), .ch_vol_i(ch_vol), .mstr_vol_i(mstr_vol),
    .mstr_mute_i(mstr_mute), .ch_mute_i(ch_mute), .zc_en_i(zc_en),
    .zd_en_i(zd_en), .atten_o(atten), .muted_o(muted)
  );

  function automatic int exp_code(input int ch, input int mv);
    if (ch == 255 || mv == 255) return 255;
    if (ch + mv > 254) return 255;
    return ch + mv;
  endfunction

  function automatic int code_of(input int c);
    return int'(atten[c*8 +: 8]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int c, input logic [23:0] d);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_chan  = 3'(c);
    smp_data  = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic base_all();
    for (int c = 0; c < 8; c++) ch_vol[c*8 +: 8] = 8'(8'h30 + c);
    mstr_vol = 8'h00;
    for (int c = 0; c < 8; c++) send(c, 24'h000123);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5171));
    rst_n = 1'b0; smp_valid = 1'b0; smp_chan = '0; smp_data = '0;
    ch_vol = {8{8'h30}}; mstr_vol = 8'hFF; mstr_mute = 1'b0; ch_mute = '0;
    zc_en = 1'b1; zd_en = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R5: reset state
    for (int c = 0; c < 8; c++) chk("R1 reset code", code_of(c), 255);
    chk("R5 reset muted", int'(muted), 255);

    // R2 R8: first sample after reset is a crossing
    zd_en = 1'b0;
    base_all();
    for (int c = 0; c < 8; c++) chk("R2 base code", code_of(c), 8'h30 + c);
    chk("R5 unmuted", int'(muted), 0);

    // R2 R3 R4 R5: random code pairs, gating off
    zc_en = 1'b0;
    for (int i = 0; i < 60; i++) begin
      automatic int c  = int'($urandom % 8);
      automatic int cv = ($urandom % 5 == 0) ? 255 : int'($urandom % 256);
      automatic int mv = ($urandom % 6 == 0) ? 255 : int'($urandom % 160);
      ch_vol[c*8 +: 8] = 8'(cv);
      mstr_vol = 8'(mv);
      send(c, 24'($urandom) | 24'd1);
      chk("R2 R3 R4 random code", code_of(c), exp_code(cv, mv));
      chk("R5 random muted", int'(muted[c]), exp_code(cv, mv) == 255 ? 1 : 0);
    end
    base_all();

    // R4: floor boundary
    ch_vol[1*8 +: 8] = 8'h80; mstr_vol = 8'h7E;
    send(1, 24'h000010);
    chk("R4 sum 254 kept", code_of(1), 254);
    chk("R5 254 not muted", int'(muted[1]), 0);
    mstr_vol = 8'h7F;
    send(1, 24'h000010);
    chk("R4 sum 255 muted", code_of(1), 255);
    base_all();

    // R8: zero-crossing gating on channel 2
    zc_en = 1'b1;
    send(2, 24'd100);
    ch_vol[2*8 +: 8] = 8'h40;
    send(2, 24'd5);
    chk("R8 same sign held", code_of(2), 8'h32);
    send(2, -24'sd5);
    chk("R8 sign change applied", code_of(2), 8'h40);
    ch_vol[2*8 +: 8] = 8'h20;
    send(2, -24'sd7);
    chk("R8 same sign held 2", code_of(2), 8'h40);
    send(2, 24'd0);
    chk("R8 zero applied", code_of(2), 8'h20);
    send(2, -24'sd3);
    ch_vol[2*8 +: 8] = 8'hFF;
    send(2, -24'sd4);
    chk("R3 hard mute ignores gating", code_of(2), 255);
    ch_vol[2*8 +: 8] = 8'h32;
    send(2, 24'd9);
    chk("R8 restore", code_of(2), 8'h32);

    // R6 R7: channel mute on channel 2 only
    ch_mute[2] = 1'b1;
    for (int i = 0; i < 31; i++) begin send(2, 24'd50); send(5, 24'd50); end
    chk("R6 before step", code_of(2), 8'h32);
    send(2, 24'd50); send(5, 24'd50);
    chk("R6 one step", code_of(2), 8'h33);
    chk("R6 other channel", code_of(5), 8'h35);
    ch_mute[2] = 1'b0;
    for (int i = 0; i < 31; i++) send(2, 24'd50);
    chk("R7 before return step", code_of(2), 8'h33);
    send(2, 24'd50);
    chk("R7 returned", code_of(2), 8'h32);
    send(2, 24'd50);

    // R6 R7: master mute on all channels
    mstr_mute = 1'b1;
    for (int i = 0; i < 32; i++) for (int c = 0; c < 8; c++) send(c, 24'd77);
    for (int c = 0; c < 8; c++) chk("R6 master step", code_of(c), 8'h31 + c);
    mstr_mute = 1'b0;
    for (int i = 0; i < 32; i++) for (int c = 0; c < 8; c++) send(c, 24'd77);
    for (int c = 0; c < 8; c++) chk("R7 master return", code_of(c), 8'h30 + c);
    for (int c = 0; c < 8; c++) send(c, 24'd77);

    // R6 R7 R5: full ramp on channel 0
    ch_mute[0] = 1'b1;
    for (int i = 0; i < 6623; i++) send(0, 24'd33);
    chk("R6 full ramp minus one", code_of(0), 254);
    chk("R5 not yet muted", int'(muted[0]), 0);
    send(0, 24'd33);
    chk("R6 full ramp", code_of(0), 255);
    chk("R5 ramp muted", int'(muted[0]), 1);
    ch_mute[0] = 1'b0;
    for (int i = 0; i < 32; i++) send(0, 24'd33);
    chk("R7 first up step", code_of(0), 254);
    for (int i = 0; i < 6592; i++) send(0, 24'd33);
    chk("R7 full return", code_of(0), 8'h30);
    send(0, 24'd33);

    // R9 R10: zero-run mute on channel 3
    zd_en = 1'b1;
    for (int i = 0; i < 2047; i++) send(3, 24'd0);
    chk("R9 2047 zeros", code_of(3), 8'h33);
    send(3, 24'd0);
    chk("R9 2048 zeros", code_of(3), 255);
    chk("R9 other channel", code_of(4), 8'h34);
    send(3, 24'd11);
    chk("R10 release", code_of(3), 8'h33);
    for (int i = 0; i < 2047; i++) send(3, 24'd0);
    chk("R10 run restarted", code_of(3), 8'h33);
    send(3, 24'd0);
    chk("R9 second run", code_of(3), 255);
    send(3, 24'd11);
    zd_en = 1'b0;
    for (int i = 0; i < 2100; i++) send(3, 24'd0);
    chk("R9 disabled", code_of(3), 8'h33);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule